// File: doc/BRIEF.md
# Pipeline Interlock and Bypass Controller

This block decides, every cycle, how a five-stage in-order integer pipeline resolves its read-after-write hazards. Operands are read in decode and written in writeback, so only true dependences need care. The block compares the source registers of the instructions in decode and execute with the destination registers of the older instructions further down the pipe. From that it chooses a bypass path for each ALU operand, and it decides whether decode must hold for a cycle. It also decides whether the instruction fetched behind a taken branch must be discarded.

A load whose result is wanted by the very next instruction cannot be bypassed in time. The block then raises a stall for one cycle. The stall freezes the program counter and the fetch/decode register and turns the decode-to-execute register into a no-op. After that cycle the load sits in the last stage and its value arrives through the writeback bypass. Branches compare and compute their target in decode, so a branch that depends on a value not yet available (the result of the instruction in execute, or a load in memory) also stalls. A mode pin chooses what happens to the instruction behind a taken branch: it always completes in delayed-slot mode, and it is squashed in squash mode.

All outputs are combinational functions of the stage fields presented in the same cycle. The pins are plain control signals with no handshake. The clock and reset serve only the embedded property checks.

Top module: `hz_unit`

## Requirements
- R1: An execute-stage operand whose register index is nonzero and equals the destination of a register-writing instruction in the memory stage gets bypass code 2'b10.
- R2: An execute-stage operand that matches a register-writing instruction in writeback, and no memory-stage producer, gets bypass code 2'b01.
- R3: When both the memory-stage and the writeback-stage producers match an operand, the memory-stage (younger) result wins with code 2'b10.
- R4: Register index 0 never causes bypassing or a stall, whatever the destination fields hold.
- R5: A producer whose write-enable is low is never a bypass source and never causes a stall.
- R6: A load in execute whose destination equals a decode source that is marked as used raises stall. A source whose use flag is low does not.
- R7: A branch in decode stalls when one of its used sources matches a register-writing instruction in execute, or a load in the memory stage.
- R8: A branch in decode is not stalled by a non-load producer in the memory stage, nor by a producer in writeback.
- R9: In squash mode (slot_mode=0), a branch in decode that is taken and not stalled raises flush_fetch.
- R10: In delayed-slot mode (slot_mode=1), flush_fetch is never raised.
- R11: flush_fetch is never raised in a cycle in which stall is high, and never for a branch that is not taken.
- R12: With no match, both bypass codes are 2'b00 (register-file value).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the property checks |
| rst_n | input | 1 | Active-low reset for the property checks |
| slot_mode | input | 1 | 1 = delayed-slot mode, 0 = squash mode |
| dec_rs1 | input | AW | First source register of the decode instruction |
| dec_rs2 | input | AW | Second source register of the decode instruction |
| dec_use1 | input | 1 | Decode instruction reads dec_rs1 |
| dec_use2 | input | 1 | Decode instruction reads dec_rs2 |
| dec_branch | input | 1 | Decode instruction is a conditional branch |
| dec_taken | input | 1 | Branch outcome resolved in decode is taken |
| ex_rs1 | input | AW | First source register of the execute instruction |
| ex_rs2 | input | AW | Second source register of the execute instruction |
| ex_rd | input | AW | Destination register of the execute instruction |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_rd | input | AW | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | AW | Destination register of the writeback instruction |
| wb_wen | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | Bypass select for ALU operand A (00 reg file, 10 memory stage, 01 writeback) |
| fwd_b | output | 2 | Bypass select for ALU operand B, same coding |
| stall | output | 1 | Hold PC and fetch/decode register and insert a bubble into execute |
| flush_fetch | output | 1 | Discard the instruction fetched behind a taken branch |

## Verification
Every result is due in the same cycle as the stage fields that cause it, because no register lies between input and output. The bench therefore applies each set of fields on the falling clock edge and samples the outputs one time unit later, well before the next rising edge. Each sample is compared against codes worked out by hand from the requirements. The embedded properties are sampled on the rising edge, when the fields have been stable for half a period.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    FWD_RF  = 2'b00,
    FWD_WB  = 2'b01,
    FWD_MEM = 2'b10
  } fwd_sel_e;

  localparam int unsigned NUM_SRC = 2;
endpackage

// File: rtl/hz_fwd_sel.sv
module hz_fwd_sel
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] src,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output fwd_sel_e      sel
);
  logic src_live;
  logic hit_mem;
  logic hit_wb;

  assign src_live = (src != '0);
  assign hit_mem  = src_live && mem_wen && (mem_rd == src);
  assign hit_wb   = src_live && wb_wen  && (wb_rd  == src);

  always_comb begin
    sel = FWD_RF;
    if (hit_mem)     sel = FWD_MEM;
    else if (hit_wb) sel = FWD_WB;
  end

  // R5: producers without write enable never feed the operand
  a_r5_no_wen_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_wen && !wb_wen) |-> (sel == FWD_RF));

  // R4: register zero always reads the register file
  a_r4_zero_reads_rf: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == FWD_RF));

  // R3: the writeback path is only chosen when memory stage does not match
  a_r3_wb_not_when_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == FWD_WB) |-> !(mem_wen && mem_rd == src));
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] dec_src [NUM_SRC],
  input  logic          dec_use [NUM_SRC],
  input  logic          dec_branch,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  output logic          stall
);
  logic [NUM_SRC-1:0] load_use;
  logic [NUM_SRC-1:0] br_wait;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic live;
    logic ex_hit;
    logic mem_hit;
    assign live    = dec_use[i] && (dec_src[i] != '0);
    assign ex_hit  = live && ex_wen  && (ex_rd  == dec_src[i]);
    assign mem_hit = live && mem_wen && (mem_rd == dec_src[i]);
    assign load_use[i] = ex_hit && ex_load;
    assign br_wait[i]  = dec_branch && (ex_hit || (mem_hit && mem_load));
  end

  assign stall = (|load_use) || (|br_wait);

  // R6: a load feeding the next instruction's used source must stall
  a_r6_load_use_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_load && ex_wen && ex_rd != '0 && dec_use[0] && dec_src[0] == ex_rd) |-> stall);

  // R5: with no writing producer in execute or memory, nothing stalls
  a_r5_quiet_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_wen && !mem_wen) |-> !stall);

  // R7: a branch waits for the instruction in execute
  a_r7_branch_waits_ex: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_branch && ex_wen && ex_rd != '0 && dec_use[1] && dec_src[1] == ex_rd) |-> stall);
endmodule

// File: rtl/hz_branch_ctl.sv
module hz_branch_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_mode,
  input  logic dec_branch,
  input  logic dec_taken,
  input  logic stall,
  output logic flush_fetch
);
  logic resolve_now;

  assign resolve_now = dec_branch && !stall;
  assign flush_fetch = resolve_now && dec_taken && !slot_mode;

  // R10: the delay slot always completes
  a_r10_slot_kept: assert property (@(posedge clk) disable iff (!rst_n)
    slot_mode |-> !flush_fetch);

  // R11: no squash while the branch is still waiting for an operand
  a_r11_no_flush_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !flush_fetch);

  // R11: a not-taken branch never squashes
  a_r11_not_taken_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_taken |-> !flush_fetch);
endmodule

// File: rtl/hz_unit.sv
module hz_unit
  import hz_pkg::*;
#(
  parameter int unsigned AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_mode,
  input  logic [AW-1:0] dec_rs1,
  input  logic [AW-1:0] dec_rs2,
  input  logic          dec_use1,
  input  logic          dec_use2,
  input  logic          dec_branch,
  input  logic          dec_taken,
  input  logic [AW-1:0] ex_rs1,
  input  logic [AW-1:0] ex_rs2,
  input  logic [AW-1:0] ex_rd,
  input  logic          ex_wen,
  input  logic          ex_load,
  input  logic [AW-1:0] mem_rd,
  input  logic          mem_wen,
  input  logic          mem_load,
  input  logic [AW-1:0] wb_rd,
  input  logic          wb_wen,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic          stall,
  output logic          flush_fetch
);
  logic [AW-1:0] ex_src  [NUM_SRC];
  logic [AW-1:0] dec_src [NUM_SRC];
  logic          dec_use [NUM_SRC];
  fwd_sel_e      sel     [NUM_SRC];

  assign ex_src[0]  = ex_rs1;
  assign ex_src[1]  = ex_rs2;
  assign dec_src[0] = dec_rs1;
  assign dec_src[1] = dec_rs2;
  assign dec_use[0] = dec_use1;
  assign dec_use[1] = dec_use2;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_opnd
    hz_fwd_sel #(.AW(AW)) u_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (ex_src[i]),
      .mem_rd  (mem_rd),
      .mem_wen (mem_wen),
      .wb_rd   (wb_rd),
      .wb_wen  (wb_wen),
      .sel     (sel[i])
    );
  end

  assign fwd_a = sel[0];
  assign fwd_b = sel[1];

  hz_interlock #(.AW(AW)) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .dec_src    (dec_src),
    .dec_use    (dec_use),
    .dec_branch (dec_branch),
    .ex_rd      (ex_rd),
    .ex_wen     (ex_wen),
    .ex_load    (ex_load),
    .mem_rd     (mem_rd),
    .mem_wen    (mem_wen),
    .mem_load   (mem_load),
    .stall      (stall)
  );

  hz_branch_ctl u_br (
    .clk         (clk),
    .rst_n       (rst_n),
    .slot_mode   (slot_mode),
    .dec_branch  (dec_branch),
    .dec_taken   (dec_taken),
    .stall       (stall),
    .flush_fetch (flush_fetch)
  );

  // R8: writeback producers alone never hold a branch
  a_r8_wb_no_branch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_branch && !ex_wen && !mem_load) |-> !stall);

  // R9: squash mode discards the fetched successor of a taken branch
  a_r9_squash_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (!slot_mode && dec_branch && dec_taken && !stall) |-> flush_fetch);
endmodule

// File: tb/sim_hz_unit.sv
module sim_hz_unit;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 5;

  typedef struct packed {
    logic [AW-1:0] d1, d2;
    logic u1, u2, br, tk;
    logic [AW-1:0] x1, x2, xd;
    logic xw, xl;
    logic [AW-1:0] md;
    logic mw, ml;
    logic [AW-1:0] wd;
    logic ww, mode;
    logic [1:0] efa, efb;
    logic est, efl;
    logic [3:0] rq;
  } vec_t;

  function automatic vec_t mk(int d1, int d2, int u1, int u2, int br, int tk,
                              int x1, int x2, int xd, int xw, int xl,
                              int md, int mw, int ml, int wd, int ww, int mode,
                              int efa, int efb, int est, int efl, int rq);
    vec_t v;
    v.d1 = AW'(d1); v.d2 = AW'(d2); v.u1 = 1'(u1); v.u2 = 1'(u2);
    v.br = 1'(br); v.tk = 1'(tk);
    v.x1 = AW'(x1); v.x2 = AW'(x2); v.xd = AW'(xd); v.xw = 1'(xw); v.xl = 1'(xl);
    v.md = AW'(md); v.mw = 1'(mw); v.ml = 1'(ml);
    v.wd = AW'(wd); v.ww = 1'(ww); v.mode = 1'(mode);
    v.efa = 2'(efa); v.efb = 2'(efb); v.est = 1'(est); v.efl = 1'(efl);
    v.rq = 4'(rq);
    return v;
  endfunction

  localparam int NV = 14;
  //                 d1 d2 u1 u2 br tk x1 x2 xd xw xl md mw ml wd ww md  fa fb st fl rq
  localparam vec_t VEC [NV] = '{
    mk( 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, 12), // R12
    mk( 0, 0, 0, 0, 0, 0, 3, 4, 0, 0, 0, 3, 1, 0, 0, 0, 1, 2, 0, 0, 0, 1),  // R1
    mk( 0, 0, 0, 0, 0, 0, 2, 7, 0, 0, 0, 0, 0, 0, 7, 1, 1, 0, 1, 0, 0, 2),  // R2
    mk( 0, 0, 0, 0, 0, 0, 5, 5, 0, 0, 0, 5, 1, 0, 5, 1, 1, 2, 2, 0, 0, 3),  // R3
    mk( 0, 0, 1, 1, 1, 0, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, 0, 4),  // R4
    mk( 6, 0, 1, 0, 0, 0, 6, 6, 6, 0, 1, 6, 0, 0, 6, 0, 1, 0, 0, 0, 0, 5),  // R5
    mk( 8, 0, 1, 0, 0, 0, 0, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 6),  // R6
    mk( 0, 8, 0, 0, 0, 0, 0, 0, 8, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6),  // R6 unused src
    mk( 9, 0, 1, 0, 1, 1, 0, 0, 9, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 7),  // R7 + R11
    mk( 0,10, 0, 1, 1, 0, 0, 0, 0, 0, 0,10, 1, 1, 0, 0, 1, 0, 0, 1, 0, 7),  // R7 load in mem
    mk(11, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0,11, 1, 0,11, 1, 0, 0, 0, 0, 1, 8),  // R8 (flush by R9)
    mk(11, 0, 1, 0, 1, 1, 0, 0, 0, 0, 0,11, 1, 0,11, 1, 1, 0, 0, 0, 0, 10), // R10
    mk( 1, 2, 1, 1, 1, 1, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 9),  // R9
    mk( 1, 2, 1, 1, 1, 0, 0, 0, 3, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 11)  // R11 not taken
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic slot_mode = 1'b0;
  logic [AW-1:0] dec_rs1 = '0, dec_rs2 = '0;
  logic dec_use1 = 1'b0, dec_use2 = 1'b0, dec_branch = 1'b0, dec_taken = 1'b0;
  logic [AW-1:0] ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
  logic ex_wen = 1'b0, ex_load = 1'b0;
  logic [AW-1:0] mem_rd = '0;
  logic mem_wen = 1'b0, mem_load = 1'b0;
  logic [AW-1:0] wb_rd = '0;
  logic wb_wen = 1'b0;
  logic [1:0] fwd_a, fwd_b;
  logic stall, flush_fetch;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hz_unit #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .slot_mode(slot_mode),
    .dec_rs1(dec_rs1), .dec_rs2(dec_rs2), .dec_use1(dec_use1), .dec_use2(dec_use2),
    .dec_branch(dec_branch), .dec_taken(dec_taken),
    .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_wen(ex_wen), .ex_load(ex_load),
    .mem_rd(mem_rd), .mem_wen(mem_wen), .mem_load(mem_load),
    .wb_rd(wb_rd), .wb_wen(wb_wen),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .stall(stall), .flush_fetch(flush_fetch)
  );

  task automatic apply(vec_t v);
    @(negedge clk);
    dec_rs1 = v.d1; dec_rs2 = v.d2; dec_use1 = v.u1; dec_use2 = v.u2;
    dec_branch = v.br; dec_taken = v.tk;
    ex_rs1 = v.x1; ex_rs2 = v.x2; ex_rd = v.xd; ex_wen = v.xw; ex_load = v.xl;
    mem_rd = v.md; mem_wen = v.mw; mem_load = v.ml;
    wb_rd = v.wd; wb_wen = v.ww; slot_mode = v.mode;
    #1;
  endtask

  task automatic check(vec_t v, string tag);
    logic [5:0] got, exp;
    total++;
    got = {fwd_a, fwd_b, stall, flush_fetch};
    exp = {v.efa, v.efb, v.est, v.efl};
    if (got !== exp) begin
      bad++;
      $display("FAIL %s R%0d: fa/fb/stall/flush actual=%b expected=%b", tag, v.rq, got, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // reset state: quiet fields give R12 codes and no control
    repeat (2) @(negedge clk);
    total++;
    if ({fwd_a, fwd_b, stall, flush_fetch} !== 6'b0) begin
      bad++;
      $display("FAIL reset R12: actual=%b expected=000000", {fwd_a, fwd_b, stall, flush_fetch});
    end
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      check(VEC[i], "table");
    end

    // R4 directed: every producer targets r0 while decode reads r0 as a loaded branch operand
    apply(mk(0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, 1, 4));
    check(mk(0, 0, 1, 1, 1, 1, 0, 0, 0, 1, 1, 0, 1, 1, 0, 1, 0, 0, 0, 0, 1, 4), "r4_zero");

    // R1 on operand B while A takes writeback (R2)
    apply(mk(0, 0, 0, 0, 0, 0, 13, 14, 0, 0, 0, 14, 1, 0, 13, 1, 1, 1, 2, 0, 0, 1));
    check(mk(0, 0, 0, 0, 0, 0, 13, 14, 0, 0, 0, 14, 1, 0, 13, 1, 1, 1, 2, 0, 0, 1), "r1_b");

    // R6 load-use through second source, highest register index
    apply(mk(0, 31, 0, 1, 0, 0, 0, 0, 31, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 6));
    check(mk(0, 31, 0, 1, 0, 0, 0, 0, 31, 1, 1, 0, 0, 0, 0, 0, 1, 0, 0, 1, 0, 6), "r6_hi");

    // R5: non-writing load in execute does not stall
    apply(mk(4, 0, 1, 0, 0, 0, 0, 0, 4, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5));
    check(mk(4, 0, 1, 0, 0, 0, 0, 0, 4, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 5), "r5_load");

    // R6 non-branch ALU producer in execute: bypass later, no stall
    apply(mk(4, 0, 1, 0, 0, 0, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6));
    check(mk(4, 0, 1, 0, 0, 0, 0, 0, 4, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 6), "r6_alu");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule